// File: doc/BRIEF.md
# MAC Control Register File

This block is the software-visible configuration and status bank of an Ethernet MAC. A simple single-cycle bus port writes and reads 32-bit registers: operating mode, interrupt source and mask, inter-packet gap settings, frame length limits, collision settings, transmit descriptor count, control mode, management-interface registers, station address and multicast hash. The same port also reaches a window onto the descriptor RAM shared with the transmit and receive engines.

Toward the engines the block presents decoded, registered configuration: enable levels, one-cycle start pulses, frame length limits, the station address in transmission order, the receive descriptor starting index and a level interrupt line. The engines raise interrupt events through a set vector and read descriptors through a second, read-only RAM port. Serial management transfers are outside this block; their registers are plain storage here.

Top module: `mac_ctrl_regfile`

## Requirements
- R1: After reset the registers read (byte offset: value) 0x00 mode 0x0000A000, 0x0C transmit descriptor count 0x40, 0x10 length limits 0x003C0600, 0x14 gap 0x12, 0x18 gap-1 0x0C, 0x1C gap-2 0x12, 0x20 collision 0x000F003F, 0x28 management mode 0x64; every other register (offsets 0x04 to 0x4C) reads zero, irq is low and rx_desc_index is 0x080.
- R2: A read issued with bus_rd in one cycle presents its data on bus_rdata in the next cycle; a written register reads back its written value, with offset 0x44 keeping bits 15:0 and the interrupt mask at 0x08 keeping bits 7:0.
- R3: A write to offset 0x0C keeps only bits 7:0 (tx_desc_count) and sets rx_desc_index to twice the written byte.
- R4: Interrupt source (offset 0x04, bits 7:0): int_set bits set it; a write clears each bit written as 1 and leaves the rest; when set and clear hit the same bit in one cycle, the set wins.
- R5: irq is the OR over bits of interrupt source AND interrupt mask (offset 0x08), valid two cycles after an int_set pulse or mask change.
- R6: A write to mode with bit 11 set returns every register, the interrupt source, the mask and rx_desc_index to their reset values.
- R7: Mode bit 0 drives rx_enable and bit 1 drives tx_enable; a write that takes a bit from 0 to 1 gives a one-cycle rx_kick or tx_kick in the cycle the enable rises, and no pulse otherwise.
- R8: Byte addresses 0x400 to 0x5FF access descriptor RAM word (address - 0x400)/4 for read and write; eng_rdata returns word eng_idx one cycle after eng_rd.
- R9: A read of any other address returns zero with bus_err high for exactly one cycle; a write there changes nothing.
- R10: Offset 0x40 holds station bytes 0..3 with byte 0 in bits 7:0, offset 0x44 holds bytes 4 and 5 with byte 4 in bits 7:0; station_addr presents byte 0 in bits 47:40 down to byte 5 in bits 7:0.
- R11: max_frame is bits 15:0 and min_frame bits 31:16 of offset 0x10; promisc is mode bit 5 and loopback mode bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped address |
| int_set | input | INT_W | Interrupt events from the engines |
| irq | output | 1 | Level interrupt |
| eng_rd | input | 1 | Engine descriptor read strobe |
| eng_idx | input | DESC_AW | Engine descriptor word index |
| eng_rdata | output | 32 | Engine descriptor read data |
| tx_enable | output | 1 | Transmit engine enable |
| rx_enable | output | 1 | Receive engine enable |
| tx_kick | output | 1 | Transmit start pulse |
| rx_kick | output | 1 | Receive start pulse |
| tx_desc_count | output | 8 | Number of transmit descriptors |
| rx_desc_index | output | 9 | Receive descriptor starting index |
| min_frame | output | 16 | Minimum frame length |
| max_frame | output | 16 | Maximum frame length |
| station_addr | output | 48 | Station address, first byte in bits 47:40 |
| promisc | output | 1 | Accept all destinations |
| loopback | output | 1 | Loop transmit into receive |

## Verification
A corrupted register shows up at the decoded outputs in the same cycle its value lands, and at bus_rdata on the next read of that offset, so every write is followed by a comparison of all decoded fields against a bench model. A stuck or mis-cleared interrupt source bit appears on irq two cycles later and on the next source read. A wrong decode or mis-sized descriptor window appears as a changed neighbour register, a wrong RAM word or a misplaced bus_err on the following read.

// File: rtl/mac_csr_pkg.sv
`timescale 1ns/1ps
package mac_csr_pkg;
  localparam int REG_COUNT   = 20;
  // word indices of the register region
  localparam int IDX_MODE    = 0;
  localparam int IDX_ISRC    = 1;
  localparam int IDX_IMASK   = 2;
  localparam int IDX_TXBD    = 3;
  localparam int IDX_PKTLEN  = 4;
  localparam int IDX_GAP     = 5;
  localparam int IDX_GAP1    = 6;
  localparam int IDX_GAP2    = 7;
  localparam int IDX_COLL    = 8;
  localparam int IDX_CTRL    = 9;
  localparam int IDX_MGMODE  = 10;
  localparam int IDX_STA_LO  = 16;
  localparam int IDX_STA_HI  = 17;
  // mode bits
  localparam int MODE_RXEN    = 0;
  localparam int MODE_TXEN    = 1;
  localparam int MODE_PROMISC = 5;
  localparam int MODE_LOOP    = 7;
  localparam int MODE_SRST    = 11;

  localparam logic [8:0] RXIDX_RESET = 9'h080;

  typedef enum logic [1:0] {SEL_NONE, SEL_REG, SEL_DESC} rd_sel_e;

  function automatic logic [31:0] reg_default(input int idx);
    case (idx)
      IDX_MODE:   return 32'h0000_A000;
      IDX_TXBD:   return 32'h0000_0040;
      IDX_PKTLEN: return 32'h003C_0600;
      IDX_GAP:    return 32'h0000_0012;
      IDX_GAP1:   return 32'h0000_000C;
      IDX_GAP2:   return 32'h0000_0012;
      IDX_COLL:   return 32'h000F_003F;
      IDX_MGMODE: return 32'h0000_0064;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] reg_wmask(input int idx);
    case (idx)
      IDX_TXBD:   return 32'h0000_00FF;
      IDX_STA_HI: return 32'h0000_FFFF;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mac_desc_ram.sv
`timescale 1ns/1ps
module mac_desc_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_idx,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_idx,
  output logic [31:0]   b_rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_idx] <= a_wdata;
      a_rdata <= mem[a_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/mac_irq_unit.sv
`timescale 1ns/1ps
module mac_irq_unit #(
  parameter int INT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic [INT_W-1:0] int_set,
  input  logic             src_wr,
  input  logic             mask_wr,
  input  logic [INT_W-1:0] wbits,
  output logic [INT_W-1:0] int_src,
  output logic [INT_W-1:0] int_mask,
  output logic             irq
);
  logic [INT_W-1:0] clr_bits;
  assign clr_bits = src_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      int_src  <= '0;
      int_mask <= '0;
    end else begin
      int_src <= (int_src & ~clr_bits) | int_set;
      if (mask_wr) int_mask <= wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(int_src & int_mask);
  end

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (src_wr && !srst) |=> ((int_src & $past(wbits & ~int_set)) == '0));

  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(int_set & int_mask)) && !mask_wr && !srst) |-> ##2 irq);

  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (int_src == '0) |=> !irq);
endmodule

// File: rtl/mac_csr_core.sv
`timescale 1ns/1ps
module mac_csr_core
  import mac_csr_pkg::*;
#(
  parameter int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output logic             tx_enable,
  output logic             rx_enable,
  output logic             tx_kick,
  output logic             rx_kick,
  output logic [7:0]       tx_desc_count,
  output logic [8:0]       rx_desc_index,
  output logic [15:0]      min_frame,
  output logic [15:0]      max_frame,
  output logic [47:0]      station_addr,
  output logic             promisc,
  output logic             loopback
);
  logic [REG_COUNT-1:0][31:0] regs;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == IDX_ISRC || i == IDX_IMASK) begin : g_hole
      assign regs[i] = '0;
    end else begin : g_flop
      localparam logic [31:0] RST_V = reg_default(i);
      localparam logic [31:0] WMASK = reg_wmask(i);
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (rst || srst)                          q <= RST_V;
        else if (wr_en && wr_idx == IDX_W'(i))    q <= wdata & WMASK;
      end
      assign regs[i] = q;
    end
  end

  logic mode_wr, txbd_wr;
  assign mode_wr = wr_en && (wr_idx == IDX_W'(IDX_MODE));
  assign txbd_wr = wr_en && (wr_idx == IDX_W'(IDX_TXBD));

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      rx_desc_index <= RXIDX_RESET;
      tx_kick       <= 1'b0;
      rx_kick       <= 1'b0;
    end else begin
      if (txbd_wr) rx_desc_index <= {wdata[7:0], 1'b0};
      tx_kick <= mode_wr && wdata[MODE_TXEN] && !regs[IDX_MODE][MODE_TXEN];
      rx_kick <= mode_wr && wdata[MODE_RXEN] && !regs[IDX_MODE][MODE_RXEN];
    end
  end

  assign rd_word = (32'(rd_idx) < REG_COUNT) ? regs[rd_idx] : 32'h0;

  assign tx_enable     = regs[IDX_MODE][MODE_TXEN];
  assign rx_enable     = regs[IDX_MODE][MODE_RXEN];
  assign promisc       = regs[IDX_MODE][MODE_PROMISC];
  assign loopback      = regs[IDX_MODE][MODE_LOOP];
  assign tx_desc_count = regs[IDX_TXBD][7:0];
  assign min_frame     = regs[IDX_PKTLEN][31:16];
  assign max_frame     = regs[IDX_PKTLEN][15:0];
  assign station_addr  = {regs[IDX_STA_LO][7:0],   regs[IDX_STA_LO][15:8],
                          regs[IDX_STA_LO][23:16], regs[IDX_STA_LO][31:24],
                          regs[IDX_STA_HI][7:0],   regs[IDX_STA_HI][15:8]};

  // R3
  rxidx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    txbd_wr |=> (rx_desc_index == {tx_desc_count, 1'b0}));

  // R7
  tx_kick_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_enable) |-> tx_kick);

  // R7
  rx_kick_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_enable) |-> rx_kick);

  // R7
  tx_kick_level_chk: assert property (@(posedge clk) disable iff (rst)
    tx_kick |-> (tx_enable && !$past(tx_enable)));

  // R6
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!tx_enable && !rx_enable && rx_desc_index == RXIDX_RESET
              && max_frame == 16'h0600 && min_frame == 16'h003C));
endmodule

// File: rtl/mac_ctrl_regfile.sv
`timescale 1ns/1ps
module mac_ctrl_regfile
  import mac_csr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int INT_W      = 8,
  parameter int DESC_DEPTH = 128,
  parameter int DESC_BASE  = 'h400,
  parameter int DESC_AW    = $clog2(DESC_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  input  logic [INT_W-1:0]   int_set,
  output logic               irq,
  input  logic               eng_rd,
  input  logic [DESC_AW-1:0] eng_idx,
  output logic [31:0]        eng_rdata,
  output logic               tx_enable,
  output logic               rx_enable,
  output logic               tx_kick,
  output logic               rx_kick,
  output logic [7:0]         tx_desc_count,
  output logic [8:0]         rx_desc_index,
  output logic [15:0]        min_frame,
  output logic [15:0]        max_frame,
  output logic [47:0]        station_addr,
  output logic               promisc,
  output logic               loopback
);
  localparam int IDX_W    = $clog2(REG_COUNT);
  localparam int REG_END  = REG_COUNT * 4;
  localparam int DESC_END = DESC_BASE + DESC_DEPTH * 4;

  logic [31:0]        addr32;
  logic               reg_hit, desc_hit;
  logic [IDX_W-1:0]   reg_idx;
  logic [DESC_AW-1:0] desc_idx;
  logic               core_wr, srst, src_wr, mask_wr;
  logic [31:0]        core_rd_word, reg_rd_val, ram_q, reg_rdata_q;
  logic [INT_W-1:0]   int_src, int_mask;
  rd_sel_e            rd_sel_q;

  assign addr32   = 32'(bus_addr);
  assign reg_hit  = addr32 < REG_END;
  assign desc_hit = (addr32 >= DESC_BASE) && (addr32 < DESC_END);
  assign reg_idx  = bus_addr[IDX_W+1:2];
  assign desc_idx = DESC_AW'((addr32 - DESC_BASE) >> 2);

  assign core_wr = bus_wr && reg_hit;
  assign srst    = core_wr && (reg_idx == IDX_W'(IDX_MODE)) && bus_wdata[MODE_SRST];
  assign src_wr  = core_wr && (reg_idx == IDX_W'(IDX_ISRC));
  assign mask_wr = core_wr && (reg_idx == IDX_W'(IDX_IMASK));

  mac_csr_core #(.IDX_W(IDX_W)) u_core (
    .clk, .rst, .srst,
    .wr_en(core_wr), .wr_idx(reg_idx), .wdata(bus_wdata),
    .rd_idx(reg_idx), .rd_word(core_rd_word),
    .tx_enable, .rx_enable, .tx_kick, .rx_kick,
    .tx_desc_count, .rx_desc_index, .min_frame, .max_frame,
    .station_addr, .promisc, .loopback
  );

  mac_irq_unit #(.INT_W(INT_W)) u_irq (
    .clk, .rst, .srst, .int_set,
    .src_wr, .mask_wr, .wbits(bus_wdata[INT_W-1:0]),
    .int_src, .int_mask, .irq
  );

  mac_desc_ram #(.DEPTH(DESC_DEPTH), .AW(DESC_AW)) u_ram (
    .clk,
    .a_en((bus_wr || bus_rd) && desc_hit), .a_we(bus_wr),
    .a_idx(desc_idx), .a_wdata(bus_wdata), .a_rdata(ram_q),
    .b_en(eng_rd), .b_idx(eng_idx), .b_rdata(eng_rdata)
  );

  always_comb begin
    reg_rd_val = core_rd_word;
    if (reg_idx == IDX_W'(IDX_ISRC))       reg_rd_val = 32'(int_src);
    else if (reg_idx == IDX_W'(IDX_IMASK)) reg_rd_val = 32'(int_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q    <= SEL_NONE;
      reg_rdata_q <= '0;
      bus_err     <= 1'b0;
    end else begin
      bus_err <= bus_rd && !reg_hit && !desc_hit;
      if (bus_rd) begin
        rd_sel_q    <= desc_hit ? SEL_DESC : (reg_hit ? SEL_REG : SEL_NONE);
        reg_rdata_q <= reg_hit ? reg_rd_val : 32'h0;
      end
    end
  end

  assign bus_rdata = (rd_sel_q == SEL_DESC) ? ram_q : reg_rdata_q;

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == 32'h0));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_rd));
endmodule

// File: tb/tb_mac_ctrl_regfile.sv
`timescale 1ns/1ps
module tb_mac_ctrl_regfile;
  localparam int NREG  = 20;
  localparam int NDESC = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  int_set = '0;
  logic        irq;
  logic        eng_rd = 1'b0;
  logic [6:0]  eng_idx = '0;
  logic [31:0] eng_rdata;
  logic        tx_enable, rx_enable, tx_kick, rx_kick;
  logic [7:0]  tx_desc_count;
  logic [8:0]  rx_desc_index;
  logic [15:0] min_frame, max_frame;
  logic [47:0] station_addr;
  logic        promisc, loopback;

  always #4 clk = ~clk;

  mac_ctrl_regfile dut (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .bus_err,
    .int_set, .irq, .eng_rd, .eng_idx, .eng_rdata,
    .tx_enable, .rx_enable, .tx_kick, .rx_kick, .tx_desc_count, .rx_desc_index,
    .min_frame, .max_frame, .station_addr, .promisc, .loopback
  );

  int checks = 0, failures = 0;
  logic [31:0] m_reg [NREG];
  logic [31:0] m_desc [NDESC];
  logic [8:0]  m_rxidx;
  logic        m_txk, m_rxk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0000A000;  3: return 32'h40;
      4: return 32'h003C0600;  5: return 32'h12;
      6: return 32'h0C;        7: return 32'h12;
      8: return 32'h000F003F; 10: return 32'h64;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m_reg[i] = dflt(i);
    m_rxidx = 9'h080;
  endtask

  task automatic model_write(input logic [10:0] a, input logic [31:0] d);
    int i;
    m_txk = 1'b0; m_rxk = 1'b0;
    if (a < 11'd80) begin
      i = int'(a >> 2);
      case (i)
        0: if (d[11]) model_reset();
           else begin
             m_txk = d[1] & ~m_reg[0][1];
             m_rxk = d[0] & ~m_reg[0][0];
             m_reg[0] = d;
           end
        1: m_reg[1] = m_reg[1] & ~(d & 32'hFF);
        2: m_reg[2] = d & 32'hFF;
        3: begin m_reg[3] = d & 32'hFF; m_rxidx = {d[7:0], 1'b0}; end
        17: m_reg[17] = d & 32'hFFFF;
        default: m_reg[i] = d;
      endcase
    end else if (a >= 11'h400 && a < 11'h600) begin
      m_desc[(a - 11'h400) >> 2] = d;
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic read_check(input string req, input logic [10:0] a);
    logic [31:0] d; logic e;
    logic [31:0] ed; logic ee;
    bus_read(a, d, e);
    if (a < 11'd80) begin ed = m_reg[a >> 2]; ee = 1'b0; end
    else if (a >= 11'h400 && a < 11'h600) begin ed = m_desc[(a - 11'h400) >> 2]; ee = 1'b0; end
    else begin ed = 32'h0; ee = 1'b1; end
    chk({req, " rdata"}, 64'(d), 64'(ed));
    chk({req, " err"}, 64'(e), 64'(ee));
  endtask

  task automatic outputs_check(input string req);
    chk({req, " R7 tx_enable"}, 64'(tx_enable), 64'(m_reg[0][1]));
    chk({req, " R7 rx_enable"}, 64'(rx_enable), 64'(m_reg[0][0]));
    chk({req, " R7 tx_kick"}, 64'(tx_kick), 64'(m_txk));
    chk({req, " R7 rx_kick"}, 64'(rx_kick), 64'(m_rxk));
    chk({req, " R3 count"}, 64'(tx_desc_count), 64'(m_reg[3][7:0]));
    chk({req, " R3 index"}, 64'(rx_desc_index), 64'(m_rxidx));
    chk({req, " R11 min"}, 64'(min_frame), 64'(m_reg[4][31:16]));
    chk({req, " R11 max"}, 64'(max_frame), 64'(m_reg[4][15:0]));
    chk({req, " R11 promisc"}, 64'(promisc), 64'(m_reg[0][5]));
    chk({req, " R11 loopback"}, 64'(loopback), 64'(m_reg[0][7]));
    chk({req, " R10 station"}, 64'(station_addr),
        64'({m_reg[16][7:0], m_reg[16][15:8], m_reg[16][23:16], m_reg[16][31:24],
             m_reg[17][7:0], m_reg[17][15:8]}));
  endtask

  task automatic all_regs_check(input string req);
    for (int i = 0; i < NREG; i++) read_check(req, 11'(i * 4));
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(negedge clk); int_set = v;
    @(negedge clk); int_set = '0;
    m_reg[1] = m_reg[1] | 32'(v);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e;
    void'($urandom(32'd20240611));
    model_reset();
    m_txk = 1'b0; m_rxk = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 err", 64'(bus_err), 64'h0);
    outputs_check("R1");
    all_regs_check("R1 reset read");

    // R8 fill descriptor RAM
    for (int i = 0; i < NDESC; i++) bus_write(11'(11'h400 + i * 4), $urandom);
    for (int i = 0; i < NDESC; i += 9) read_check("R8 desc", 11'(11'h400 + i * 4));
    read_check("R8 last desc word", 11'h5FC);

    // R10 station address
    bus_write(11'h040, 32'h44332211);
    bus_write(11'h044, 32'hAABB6655);
    chk("R10 station order", 64'(station_addr), 64'h112233445566);
    read_check("R10 hi masked", 11'h044);

    // R3 descriptor count
    bus_write(11'h00C, 32'hFFFF_F1FF);
    chk("R3 count low byte", 64'(tx_desc_count), 64'hFF);
    chk("R3 rx index", 64'(rx_desc_index), 64'h1FE);
    read_check("R3 readback", 11'h00C);

    // R7 kick pulses
    bus_write(11'h000, 32'h0000A002);
    chk("R7 tx kick on rise", 64'(tx_kick), 64'h1);
    chk("R7 no rx kick", 64'(rx_kick), 64'h0);
    @(negedge clk);
    chk("R7 tx kick one cycle", 64'(tx_kick), 64'h0);
    chk("R7 tx stays enabled", 64'(tx_enable), 64'h1);
    bus_write(11'h000, 32'h0000A003);
    chk("R7 no tx kick when held", 64'(tx_kick), 64'h0);
    chk("R7 rx kick on rise", 64'(rx_kick), 64'h1);
    bus_write(11'h000, 32'h0000A000);
    chk("R7 tx stopped", 64'(tx_enable), 64'h0);
    chk("R7 rx stopped", 64'(rx_enable), 64'h0);

    // R4 / R5 interrupts
    bus_write(11'h008, 32'h0000_0005);
    pulse_set(8'h04);
    @(negedge clk);
    chk("R5 irq after masked event", 64'(irq), 64'h1);
    read_check("R4 source set", 11'h004);
    pulse_set(8'h02);
    bus_write(11'h004, 32'h0000_0004);
    read_check("R4 w1c keeps others", 11'h004);
    @(negedge clk); @(negedge clk);
    chk("R5 irq low when only unmasked bit", 64'(irq), 64'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 11'h004; bus_wdata = 32'h08; int_set = 8'h08;
    @(negedge clk);
    bus_wr = 1'b0; int_set = '0;
    m_reg[1] = m_reg[1] | 32'h08;
    read_check("R4 set wins over clear", 11'h004);
    bus_write(11'h004, 32'hFFFF_FFFF);
    read_check("R4 clear all", 11'h004);
    @(negedge clk); @(negedge clk);
    chk("R5 irq cleared", 64'(irq), 64'h0);

    // R9 unmapped reads
    read_check("R9 unmapped low", 11'h050);
    @(negedge clk);
    chk("R9 err one cycle", 64'(bus_err), 64'h0);
    read_check("R9 unmapped high", 11'h600);
    read_check("R9 last register mapped", 11'h04C);
    read_check("R9 below window", 11'h3FC);

    // R8 engine port
    @(negedge clk); eng_rd = 1'b1; eng_idx = 7'd5;
    @(negedge clk); eng_rd = 1'b0;
    chk("R8 engine read", 64'(eng_rdata), 64'(m_desc[5]));
    @(negedge clk); eng_rd = 1'b1; eng_idx = 7'd127;
    @(negedge clk); eng_rd = 1'b0;
    chk("R8 engine last word", 64'(eng_rdata), 64'(m_desc[127]));

    // R6 soft reset
    bus_write(11'h010, 32'h0040_0100);
    bus_write(11'h024, 32'h1234_5678);
    bus_write(11'h048, 32'hDEAD_BEEF);
    bus_write(11'h00C, 32'h0000_0010);
    bus_write(11'h008, 32'h0000_00FF);
    bus_write(11'h000, 32'h0000_A0A3);
    pulse_set(8'h81);
    bus_write(11'h000, 32'h0000_0800);
    outputs_check("R6 after soft reset");
    all_regs_check("R6 soft reset read");
    @(negedge clk); @(negedge clk);
    chk("R6 irq after soft reset", 64'(irq), 64'h0);

    // random mix (R2 R3 R7 R8 R9 R10 R11)
    for (int n = 0; n < 400; n++) begin
      int kind; logic [31:0] rv; int ri;
      kind = int'($urandom_range(0, 5));
      rv   = $urandom;
      case (kind)
        0: begin
          ri = int'($urandom_range(0, NREG - 1));
          if (ri == 0) rv[11] = 1'b0;
          bus_write(11'(ri * 4), rv);
          outputs_check("R2 random write");
        end
        1: read_check("R2 random reg read", 11'(int'($urandom_range(0, NREG - 1)) * 4));
        2: bus_write(11'(11'h400 + int'($urandom_range(0, NDESC - 1)) * 4), rv);
        3: read_check("R8 random desc read", 11'(11'h400 + int'($urandom_range(0, NDESC - 1)) * 4));
        4: read_check("R9 random unmapped read",
                      ($urandom_range(0, 1) == 0) ? 11'(int'($urandom_range(20, 255)) * 4)
                                                  : 11'(int'($urandom_range(384, 511)) * 4));
        default: begin
          bus_write(11'(int'($urandom_range(384, 511)) * 4), rv);
          outputs_check("R9 random unmapped write");
        end
      endcase
    end

    // R9 unmapped writes leave everything intact
    bus_write(11'h050, 32'hFFFF_FFFF);
    bus_write(11'h7FC, 32'hFFFF_FFFF);
    bus_write(11'h3FC, 32'hFFFF_FFFF);
    outputs_check("R9 after unmapped writes");
    all_regs_check("R9 regs unchanged");
    read_check("R9 desc unchanged", 11'h400);
    read_check("R9 desc top unchanged", 11'h5FC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule